// File: doc/BRIEF.md
# Speculative Path History Queue

This block keeps, for every hardware thread, an ordered record of the most recent indirect branches. Each record holds the branch address, its target and the sequence number of the branch. A branch is appended at the young end as soon as it is predicted. As branches retire, commits advance a retained-history boundary. A misprediction squashes every record younger than the offending sequence number. When a branch resolves, its target can be corrected in place.

A target-hashing unit reads, for one selected thread, the few youngest targets and a count of how many are valid. It also reads the youngest entry's branch address, which a target table needs when it updates. Per thread, the queue retains up to `PATH_LEN` committed entries as older path history. Entries past that boundary are speculative. When the queue is full, a new push evicts the oldest record.

Each cycle the block accepts one operation on one thread. When several operation strobes are raised together, a fixed priority picks one and the others are dropped.

Top module: `path_hist_queue`

## Requirements
- R1: A push on thread `tid_i` appends {`addr_i`, `tgt_i`, `seq_i`} at the young end. From the next cycle that target is in view slot 0 and `yng_addr_o` shows that address.
- R2: The view bus has one slot per `ADDR_W` field. Slot p sits at bits [p*ADDR_W +: ADDR_W] and holds the target of the p-th youngest entry, with slot 0 the youngest. Slots at or beyond the entry count read zero. `hist_cnt_o` equals the entry count saturated at `PATH_LEN`.
- R3: A commit with sequence S does nothing in three cases: the thread is empty, the head index equals the entry count, or the entry at the head index has a sequence number greater than S.
- R4: A commit that qualifies increments the head index while the index is below `PATH_LEN`. Once the index has reached `PATH_LEN`, a qualifying commit removes the oldest entry instead.
- R5: A squash with sequence S finds the oldest entry whose sequence number exceeds S and removes it together with every younger entry. If no entry exceeds S, nothing changes. The head index is then limited to the new entry count.
- R6: A target write replaces only the target of the youngest entry; its address and sequence number are kept. On an empty thread the write has no effect.
- R7: A push onto a thread that already holds `DEPTH` entries evicts the oldest entry. If the head index is nonzero, it is decremented by one.
- R8: Operations act only on thread `tid_i`. Every other thread's contents are unchanged. `rd_tid_i` selects the thread shown on the view outputs.
- R9: When several strobes are raised in one cycle, only one takes effect. The priority order is squash, then target write, then push, then commit.
- R10: After reset every thread is empty. The view slots, `hist_cnt_o` and `yng_addr_o` all read zero.
- R11: Sequence numbers are compared as unsigned values of `SEQ_W` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Append a new entry |
| commit_i | input | 1 | Commit up to `seq_i` |
| squash_i | input | 1 | Remove entries younger than `seq_i` |
| tgt_wr_i | input | 1 | Rewrite the youngest target with `tgt_i` |
| tid_i | input | TID_W | Thread the operation acts on |
| addr_i | input | ADDR_W | Branch address for a push |
| tgt_i | input | ADDR_W | Target for a push or a target write |
| seq_i | input | SEQ_W | Sequence number for push, commit or squash |
| rd_tid_i | input | TID_W | Thread shown on the view outputs |
| hist_tgt_o | output | PATH_LEN*ADDR_W | Youngest targets, slot 0 youngest |
| hist_cnt_o | output | CNT_W | Valid slots, saturated at `PATH_LEN` |
| yng_addr_o | output | ADDR_W | Branch address of the youngest entry, zero when empty |

## Verification
The bench targets four corner cases.

- Commit at the retention boundary. A design that advanced the head past `PATH_LEN`, or popped too early, would keep the wrong older entries. A later squash exposes this: the count and the targets left behind are wrong.
- Overflow eviction. A full queue pushed again must drop exactly one oldest record and pull the head back. The bench then commits and squashes down to a single entry, so a missing head decrement shows up as an empty thread.
- Strobe priority and unsigned comparison. A squash that let a simultaneous push through, or a comparison done as signed, leaves one entry too many.
- Thread isolation. A thread that leaked operations into another would change that thread's view.

A behavioural model built from shifting arrays follows every cycle of a long random run.

// File: rtl/path_hist_pkg.sv
package path_hist_pkg;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_SQUASH = 3'd1,
    OP_TGTWR  = 3'd2,
    OP_PUSH   = 3'd3,
    OP_COMMIT = 3'd4
  } op_e;

  // one operation per cycle, fixed priority (R9)
  function automatic op_e pick_op(input logic squash, input logic tgt_wr,
                                  input logic push, input logic commit);
    if (squash)      return OP_SQUASH;
    else if (tgt_wr) return OP_TGTWR;
    else if (push)   return OP_PUSH;
    else if (commit) return OP_COMMIT;
    else             return OP_NONE;
  endfunction

endpackage

// File: rtl/path_hist_first_set.sv
module path_hist_first_set #(
  parameter  int N     = 8,
  localparam int IDX_W = $clog2(N + 1)
) (
  input  logic [N-1:0]     vec_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);

  // lowest set bit wins: the oldest matching entry
  always_comb begin
    hit_o = |vec_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end

endmodule

// File: rtl/path_hist_thread.sv
module path_hist_thread
  import path_hist_pkg::*;
#(
  parameter  int DEPTH    = 8,
  parameter  int PATH_LEN = 3,
  parameter  int ADDR_W   = 32,
  parameter  int SEQ_W    = 16,
  localparam int PTR_W    = $clog2(DEPTH),
  localparam int OCC_W    = $clog2(DEPTH + 1),
  localparam int CNT_W    = $clog2(PATH_LEN + 1)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  op_e                            op_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [ADDR_W-1:0]              tgt_i,
  input  logic [SEQ_W-1:0]               seq_i,
  output logic [PATH_LEN-1:0][ADDR_W-1:0] hist_tgt_o,
  output logic [CNT_W-1:0]               hist_cnt_o,
  output logic [ADDR_W-1:0]              yng_addr_o,
  output logic [OCC_W-1:0]               occ_o,
  output logic [OCC_W-1:0]               head_o
);

  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [ADDR_W-1:0] tgt_q  [DEPTH];
  logic [SEQ_W-1:0]  seq_q  [DEPTH];

  logic [PTR_W-1:0]  rd_q;
  logic [OCC_W-1:0]  occ_q;
  logic [OCC_W-1:0]  head_q;

  logic [PTR_W-1:0]  wr_idx, yng_idx, head_idx;
  logic              empty, full, cm_ok;
  logic [DEPTH-1:0]  younger;
  logic              sq_hit;
  logic [OCC_W-1:0]  sq_idx;

  assign wr_idx   = rd_q + occ_q[PTR_W-1:0];
  assign yng_idx  = wr_idx - PTR_W'(1);
  assign head_idx = rd_q + head_q[PTR_W-1:0];
  assign empty    = (occ_q == '0);
  assign full     = (occ_q == OCC_W'(DEPTH));
  assign cm_ok    = !empty && (head_q < occ_q) && (seq_q[head_idx] <= seq_i);

  // entries, oldest first, that are younger than the squash point
  for (genvar i = 0; i < DEPTH; i++) begin : g_scan
    assign younger[i] = (OCC_W'(i) < occ_q) &&
                        (seq_q[rd_q + PTR_W'(i)] > seq_i);
  end

  path_hist_first_set #(
    .N(DEPTH)
  ) u_scan (
    .vec_i (younger),
    .hit_o (sq_hit),
    .idx_o (sq_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q   <= '0;
      occ_q  <= '0;
      head_q <= '0;
    end else begin
      case (op_i)
        OP_SQUASH: begin
          if (sq_hit) begin
            occ_q <= sq_idx;
            if (head_q > sq_idx) head_q <= sq_idx;
          end
        end
        OP_PUSH: begin
          if (full) begin
            rd_q <= rd_q + PTR_W'(1);
            if (head_q != '0) head_q <= head_q - OCC_W'(1);
          end else begin
            occ_q <= occ_q + OCC_W'(1);
          end
        end
        OP_COMMIT: begin
          if (cm_ok) begin
            if (head_q >= OCC_W'(PATH_LEN)) begin
              rd_q  <= rd_q + PTR_W'(1);
              occ_q <= occ_q - OCC_W'(1);
            end else begin
              head_q <= head_q + OCC_W'(1);
            end
          end
        end
        default: ;
      endcase
    end
  end

  // payload storage, no reset: reads are masked by occ_q
  always_ff @(posedge clk_i) begin
    if (op_i == OP_PUSH) begin
      addr_q[wr_idx] <= addr_i;
      tgt_q[wr_idx]  <= tgt_i;
      seq_q[wr_idx]  <= seq_i;
    end else if (op_i == OP_TGTWR && !empty) begin
      tgt_q[yng_idx] <= tgt_i;
    end
  end

  for (genvar p = 0; p < PATH_LEN; p++) begin : g_view
    logic [PTR_W-1:0] pidx;
    assign pidx          = wr_idx - PTR_W'(p + 1);
    assign hist_tgt_o[p] = (OCC_W'(p) < occ_q) ? tgt_q[pidx] : '0;
  end

  assign hist_cnt_o = (occ_q >= OCC_W'(PATH_LEN)) ? CNT_W'(PATH_LEN) : CNT_W'(occ_q);
  assign yng_addr_o = empty ? '0 : addr_q[yng_idx];
  assign occ_o      = occ_q;
  assign head_o     = head_q;

endmodule

// File: rtl/path_hist_queue.sv
module path_hist_queue
  import path_hist_pkg::*;
#(
  parameter  int NUM_THREADS = 2,
  parameter  int DEPTH       = 8,
  parameter  int PATH_LEN    = 3,
  parameter  int ADDR_W      = 32,
  parameter  int SEQ_W       = 16,
  localparam int TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int OCC_W       = $clog2(DEPTH + 1),
  localparam int CNT_W       = $clog2(PATH_LEN + 1)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         push_i,
  input  logic                         commit_i,
  input  logic                         squash_i,
  input  logic                         tgt_wr_i,
  input  logic [TID_W-1:0]             tid_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [ADDR_W-1:0]            tgt_i,
  input  logic [SEQ_W-1:0]             seq_i,
  input  logic [TID_W-1:0]             rd_tid_i,
  output logic [PATH_LEN*ADDR_W-1:0]   hist_tgt_o,
  output logic [CNT_W-1:0]             hist_cnt_o,
  output logic [ADDR_W-1:0]            yng_addr_o
);

  op_e op;
  op_e thr_op [NUM_THREADS];

  logic [PATH_LEN-1:0][ADDR_W-1:0] thr_hist [NUM_THREADS];
  logic [CNT_W-1:0]                thr_cnt  [NUM_THREADS];
  logic [ADDR_W-1:0]               thr_yng  [NUM_THREADS];
  logic [NUM_THREADS-1:0][OCC_W-1:0] occ_w;
  logic [NUM_THREADS-1:0][OCC_W-1:0] head_w;

  assign op = pick_op(squash_i, tgt_wr_i, push_i, commit_i);

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    assign thr_op[t] = (tid_i == TID_W'(t)) ? op : OP_NONE;

    path_hist_thread #(
      .DEPTH    (DEPTH),
      .PATH_LEN (PATH_LEN),
      .ADDR_W   (ADDR_W),
      .SEQ_W    (SEQ_W)
    ) u_thr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .op_i       (thr_op[t]),
      .addr_i     (addr_i),
      .tgt_i      (tgt_i),
      .seq_i      (seq_i),
      .hist_tgt_o (thr_hist[t]),
      .hist_cnt_o (thr_cnt[t]),
      .yng_addr_o (thr_yng[t]),
      .occ_o      (occ_w[t]),
      .head_o     (head_w[t])
    );
  end

  assign hist_tgt_o = thr_hist[rd_tid_i];
  assign hist_cnt_o = thr_cnt[rd_tid_i];
  assign yng_addr_o = thr_yng[rd_tid_i];

endmodule

// File: rtl/path_hist_queue_chk.sv
module path_hist_queue_chk #(
  parameter  int NUM_THREADS = 2,
  parameter  int DEPTH       = 8,
  parameter  int PATH_LEN    = 3,
  localparam int TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int OCC_W       = $clog2(DEPTH + 1),
  localparam int CNT_W       = $clog2(PATH_LEN + 1)
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           push_i,
  input logic                           commit_i,
  input logic                           squash_i,
  input logic                           tgt_wr_i,
  input logic [TID_W-1:0]               tid_i,
  input logic [NUM_THREADS-1:0][OCC_W-1:0] occ_i,
  input logic [NUM_THREADS-1:0][OCC_W-1:0] head_i,
  input logic [CNT_W-1:0]               hist_cnt_i
);

  assert_cnt_sat_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hist_cnt_i <= CNT_W'(PATH_LEN));

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_t
    assert_occ_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      occ_i[t] <= OCC_W'(DEPTH));

    assert_head_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (head_i[t] <= occ_i[t]) && (head_i[t] <= OCC_W'(PATH_LEN)));

    assert_push_grows_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (push_i && !squash_i && !tgt_wr_i && tid_i == TID_W'(t) && occ_i[t] < OCC_W'(DEPTH))
      |=> occ_i[t] == $past(occ_i[t]) + OCC_W'(1));

    assert_commit_no_grow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (commit_i && !push_i && !squash_i && !tgt_wr_i && tid_i == TID_W'(t))
      |=> occ_i[t] <= $past(occ_i[t]));

    assert_squash_shrinks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (squash_i && tid_i == TID_W'(t)) |=> occ_i[t] <= $past(occ_i[t]));

    assert_tgtwr_keeps_occ_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tgt_wr_i && !squash_i && tid_i == TID_W'(t)) |=> $stable(occ_i[t]));

    assert_thread_isolated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tid_i != TID_W'(t)) |=> $stable(occ_i[t]) && $stable(head_i[t]));

    assert_push_dropped_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tgt_wr_i && push_i && !squash_i && tid_i == TID_W'(t))
      |=> $stable(head_i[t]));
  end

endmodule

bind path_hist_queue path_hist_queue_chk #(
  .NUM_THREADS (NUM_THREADS),
  .DEPTH       (DEPTH),
  .PATH_LEN    (PATH_LEN)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .push_i     (push_i),
  .commit_i   (commit_i),
  .squash_i   (squash_i),
  .tgt_wr_i   (tgt_wr_i),
  .tid_i      (tid_i),
  .occ_i      (occ_w),
  .head_i     (head_w),
  .hist_cnt_i (hist_cnt_o)
);

// File: tb/path_hist_queue_tb.sv
`timescale 1ns/1ps
module path_hist_queue_tb;

  localparam int NT    = 2;
  localparam int DEPTH = 8;
  localparam int PL    = 3;
  localparam int AW    = 32;
  localparam int SW    = 16;
  localparam int CW    = $clog2(PL + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          push = 0, commit = 0, squash = 0, tgt_wr = 0;
  logic          tid = 0, rd_tid = 0;
  logic [AW-1:0] addr = '0, tgt = '0;
  logic [SW-1:0] seq = '0;
  logic [PL*AW-1:0] hist;
  logic [CW-1:0]    cnt;
  logic [AW-1:0]    yng;

  path_hist_queue #(
    .NUM_THREADS(NT), .DEPTH(DEPTH), .PATH_LEN(PL), .ADDR_W(AW), .SEQ_W(SW)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .push_i(push), .commit_i(commit),
    .squash_i(squash), .tgt_wr_i(tgt_wr), .tid_i(tid), .addr_i(addr),
    .tgt_i(tgt), .seq_i(seq), .rd_tid_i(rd_tid), .hist_tgt_o(hist),
    .hist_cnt_o(cnt), .yng_addr_o(yng)
  );

  // behavioural reference: index 0 is the oldest entry, shifted on removal
  logic [AW-1:0] m_addr [NT][DEPTH];
  logic [AW-1:0] m_tgt  [NT][DEPTH];
  logic [SW-1:0] m_seq  [NT][DEPTH];
  int m_cnt [NT];
  int m_head [NT];

  int n_chk = 0, n_fail = 0;
  bit live = 0, done = 0;
  string phase = "R10";

  task automatic chk(input string req, input string what,
                     input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] slot(input int p);
    return hist[p*AW +: AW];
  endfunction

  task automatic m_drop_oldest(input int t);
    for (int k = 0; k < DEPTH - 1; k++) begin
      m_addr[t][k] = m_addr[t][k+1];
      m_tgt[t][k]  = m_tgt[t][k+1];
      m_seq[t][k]  = m_seq[t][k+1];
    end
    m_cnt[t]--;
  endtask

  always @(posedge clk) begin : model
    int t, k;
    if (!rst_n) begin
      for (int i = 0; i < NT; i++) begin
        m_cnt[i] = 0;
        m_head[i] = 0;
      end
    end else begin
      t = int'(tid);
      if (squash) begin
        k = -1;
        for (int i = m_cnt[t] - 1; i >= 0; i--) if (m_seq[t][i] > seq) k = i;
        if (k >= 0) begin
          m_cnt[t] = k;
          if (m_head[t] > k) m_head[t] = k;
        end
      end else if (tgt_wr) begin
        if (m_cnt[t] > 0) m_tgt[t][m_cnt[t]-1] = tgt;
      end else if (push) begin
        if (m_cnt[t] == DEPTH) begin
          m_drop_oldest(t);
          if (m_head[t] > 0) m_head[t]--;
        end
        m_addr[t][m_cnt[t]] = addr;
        m_tgt[t][m_cnt[t]]  = tgt;
        m_seq[t][m_cnt[t]]  = seq;
        m_cnt[t]++;
      end else if (commit) begin
        if (m_cnt[t] > 0 && m_head[t] < m_cnt[t] && m_seq[t][m_head[t]] <= seq) begin
          if (m_head[t] >= PL) m_drop_oldest(t);
          else m_head[t]++;
        end
      end
    end
  end

  always @(negedge clk) begin : compare
    int r, c;
    logic [AW-1:0] e;
    if (live) begin
      r = int'(rd_tid);
      c = m_cnt[r];
      for (int p = 0; p < PL; p++) begin
        e = (p < c) ? m_tgt[r][c-1-p] : '0;
        chk(phase, "model slot", slot(p), e);
      end
      chk(phase, "model count", AW'(cnt), AW'((c > PL) ? PL : c));
      chk(phase, "model yng_addr", yng, (c > 0) ? m_addr[r][c-1] : '0);
    end
  end

  task automatic op(input bit p, input bit c, input bit s, input bit w, input int t,
                    input logic [AW-1:0] a, input logic [AW-1:0] g,
                    input logic [SW-1:0] q);
    @(posedge clk); #1;
    push = p; commit = c; squash = s; tgt_wr = w;
    tid = t[0]; addr = a; tgt = g; seq = q;
  endtask

  task automatic pu(input int t, input logic [AW-1:0] a,
                    input logic [AW-1:0] g, input logic [SW-1:0] q);
    op(1, 0, 0, 0, t, a, g, q);
  endtask

  task automatic settle(input int v);
    @(posedge clk); #1;
    push = 0; commit = 0; squash = 0; tgt_wr = 0; rd_tid = v[0];
    @(negedge clk);
  endtask

  initial begin : wdog
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    int nseq [NT];
    int t, r, ds;
    bit p, c, s, w;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R10: reset state
    chk("R10", "count", AW'(cnt), '0);
    chk("R10", "slot0", slot(0), '0);
    chk("R10", "yng_addr", yng, '0);
    live = 1;

    phase = "R1";
    pu(0, 32'h100, 32'h1000, 10);
    pu(0, 32'h104, 32'h1100, 20);
    pu(0, 32'h108, 32'h1200, 30);
    pu(0, 32'h10C, 32'h1300, 40);
    settle(0);
    chk("R1", "yng_addr", yng, 32'h10C);
    chk("R1", "slot0", slot(0), 32'h1300);
    chk("R2", "slot1", slot(1), 32'h1200);
    chk("R2", "slot2", slot(2), 32'h1100);
    chk("R2", "count", AW'(cnt), 3);

    phase = "R6";
    op(0, 0, 0, 1, 0, '0, 32'h1AAA, '0);
    settle(0);
    chk("R6", "slot0", slot(0), 32'h1AAA);
    chk("R6", "yng_addr", yng, 32'h10C);
    chk("R6", "slot1", slot(1), 32'h1200);

    phase = "R4";
    op(0, 1, 0, 0, 0, '0, '0, 5);    // R3: head seq 10 > 5
    op(0, 1, 0, 0, 1, '0, '0, 99);   // R3: empty thread
    op(0, 1, 0, 0, 0, '0, '0, 10);
    op(0, 1, 0, 0, 0, '0, '0, 20);
    op(0, 1, 0, 0, 0, '0, '0, 30);
    op(0, 1, 0, 0, 0, '0, '0, 40);   // head at PATH_LEN: oldest dropped
    op(0, 0, 1, 0, 0, '0, '0, 20);
    settle(0);
    chk("R4", "count after pop+squash", AW'(cnt), 1);
    chk("R4", "slot0", slot(0), 32'h1100);
    chk("R5", "slot1 cleared", slot(1), '0);

    phase = "R7";
    for (int i = 1; i <= 10; i++) pu(1, 32'h200 + 4*i, 32'h2000 + 16*i, SW'(i));
    settle(1);
    chk("R7", "slot0 full", slot(0), 32'h20A0);
    op(0, 0, 1, 0, 1, '0, '0, 4);
    settle(1);
    chk("R7", "count after evict", AW'(cnt), 2);
    chk("R7", "slot0", slot(0), 32'h2040);
    chk("R7", "slot1 oldest kept", slot(1), 32'h2030);
    settle(0);
    chk("R8", "thread0 count untouched", AW'(cnt), 1);
    chk("R8", "thread0 slot0 untouched", slot(0), 32'h1100);

    phase = "R9";
    op(1, 0, 1, 0, 0, 32'h1F0, 32'h1F00, 0);
    settle(0);
    chk("R9", "squash beats push", AW'(cnt), 0);
    pu(0, 32'h120, 32'h1500, 70);
    op(1, 0, 0, 1, 0, 32'h124, 32'h1555, 80);
    settle(0);
    chk("R9", "tgt write beats push cnt", AW'(cnt), 1);
    chk("R9", "tgt write beats push slot0", slot(0), 32'h1555);
    chk("R9", "yng_addr", yng, 32'h120);
    op(1, 1, 0, 0, 0, 32'h128, 32'h1600, 90);
    settle(0);
    chk("R9", "push beats commit", slot(0), 32'h1600);

    phase = "R11";
    op(0, 0, 1, 0, 1, '0, '0, 0);
    pu(1, 32'h300, 32'h3000, 16'h7FFF);
    pu(1, 32'h304, 32'h3100, 16'h8000);
    op(0, 0, 1, 0, 1, '0, '0, 16'h7FFF);
    settle(1);
    chk("R11", "unsigned squash count", AW'(cnt), 1);
    chk("R11", "slot0", slot(0), 32'h3000);

    phase = "R7";
    op(0, 0, 1, 0, 1, '0, '0, 0);
    for (int i = 1; i <= 3; i++) pu(1, 32'h200 + 4*i, 32'h2000 + 16*i, SW'(i));
    for (int i = 1; i <= 3; i++) op(0, 1, 0, 0, 1, '0, '0, SW'(i));
    for (int i = 4; i <= 9; i++) pu(1, 32'h200 + 4*i, 32'h2000 + 16*i, SW'(i));
    op(0, 1, 0, 0, 1, '0, '0, 9);
    op(0, 1, 0, 0, 1, '0, '0, 9);
    op(0, 0, 1, 0, 1, '0, '0, 3);
    settle(1);
    chk("R7", "head pulled back on evict", AW'(cnt), 1);
    chk("R7", "slot0", slot(0), 32'h2030);

    phase = "R2 random";
    nseq[0] = 200; nseq[1] = 200;
    for (int i = 0; i < 3000; i++) begin
      t = $urandom % NT;
      r = $urandom % 16;
      p = 0; c = 0; s = 0; w = 0;
      if (r < 6) p = 1;
      else if (r < 9) c = 1;
      else if (r == 9) s = 1;
      else if (r == 10) w = 1;
      else if (r == 11) begin
        p = 1; c = 1; w = $urandom % 2; s = ($urandom % 4 == 0);
      end
      if (p) nseq[t] += 1 + $urandom % 3;
      ds = s ? $urandom % 6 : (c ? $urandom % 10 : 0);
      rd_tid = $urandom % NT;
      op(p, c, s, w, t, $urandom, $urandom, SW'(nseq[t] - ds));
    end
    settle(0);
    settle(1);

    done = 1;
    live = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule